// File: doc/BRIEF.md
# Max-Min Capacitor Voltage Balancing Selector

This block decides, for one converter arm of `N_SM` sub-modules, which sub-modules are inserted into the arm and which are bypassed. It is driven once per control cycle. A single-cycle strobe supplies four inputs: the number of modules that must be inserted (from an upstream level modulator), the signed arm current, every capacitor voltage and a swap threshold. The block then walks from the stored state to a new one and changes as few sub-modules as it can. Each time it picks the module whose capacitor voltage is extreme in the direction that helps balance.

When the required count rises or falls by `d`, exactly `d` modules change state, one per clock. Each is taken by a fresh max or min scan over the modules still eligible. When the count is unchanged, at most one inserted/bypassed pair is exchanged, and only if their voltage gap exceeds the threshold. This keeps the switching rate low while still steering charge toward the weakest or strongest cells. When the update is finished the block pulses `done_o`, and `ins_o` holds the new state vector.

Top module: `mmc_maxmin_sel`

## Requirements
- R1: After reset every bit of `ins_o` is 0 (bit i = 1 means sub-module i is inserted), `done_o` and `busy_o` are 0, and the stored previous count is zero.
- R2: When the clamped request exceeds the previous count by d and the arm current is not negative (charging), the d bypassed modules with the lowest voltages are inserted.
- R3: When the clamped request exceeds the previous count by d and the arm current is negative (discharging), the d bypassed modules with the highest voltages are inserted.
- R4: When the clamped request is below the previous count by d, the d inserted modules are bypassed: those with the highest voltages when charging, those with the lowest when discharging.
- R5: With an unchanged count, the pair is chosen by the current direction. When charging it is the highest-voltage inserted module and the lowest-voltage bypassed module; when discharging it is the lowest-voltage inserted module and the highest-voltage bypassed module. The pair exchanges states only if the absolute difference of their voltages is strictly greater than `thresh_i`. Otherwise nothing changes.
- R6: Only modules selected by R2 to R5 change state; at most one module changes per clock (two during a swap), and after each update the number of inserted modules equals the clamped request.
- R7: Equal voltages are resolved toward the lowest sub-module index.
- R8: A request above `N_SM` is treated as `N_SM`.
- R9: `arm_cur_i` is signed two's complement, and a current of exactly zero is handled as charging.
- R10: `done_o` is high for exactly one clock. It rises `max(d,1)+1` clock edges after the strobe edge. `ins_o` does not change while `busy_o` is low, and a strobe that arrives while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Control-cycle strobe, accepted only when idle |
| req_cnt_i | input | CW | Required number of inserted modules |
| arm_cur_i | input | IW | Signed arm current |
| volt_i | input | N_SM*VW | Capacitor voltages, module i at bits [i*VW +: VW] |
| thresh_i | input | VW | Swap threshold for the unchanged-count case |
| busy_o | output | 1 | Update in progress |
| done_o | output | 1 | One-clock pulse when the update is complete |
| ins_o | output | N_SM | Inserted state per sub-module |

## Verification
The voltages are drawn from a narrow range so that ties are frequent. A bench model that uses only the requirement rules predicts the result of every update in a long random sequence of requests and current signs. This separates rising, falling and unchanged counts in both current directions. Directed patterns cover the remaining cases:
- all-equal voltages, which expose the tie order;
- a zero current, which must behave as charging;
- an out-of-range request, which must be clamped;
- thresholds at both ends, which separate swap from no swap;
- a strobe injected mid-update, which must be ignored.

// File: rtl/mmc_sel_pkg.sv
package mmc_sel_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_STEP = 2'd1,
      ST_SWAP = 2'd2,
      ST_FIN  = 2'd3
   } sel_state_e;
endpackage

// File: rtl/mmc_extreme_finder.sv
module mmc_extreme_finder #(
   parameter int N_SM = 8,
   parameter int VW   = 10,
   localparam int IXW = (N_SM > 1) ? $clog2(N_SM) : 1
) (
   input  logic [N_SM*VW-1:0] volt_i,
   input  logic [N_SM-1:0]    elig_i,
   input  logic               find_max_i,
   output logic [IXW-1:0]     idx_o,
   output logic               found_o
);
   logic [VW-1:0] best;

   // Linear scan, strict compare keeps the lowest index on ties.
   always_comb begin
      idx_o   = '0;
      found_o = 1'b0;
      best    = '0;
      for (int i = 0; i < N_SM; i++) begin
         if (elig_i[i]) begin
            if (!found_o ||
                ( find_max_i && (volt_i[i*VW +: VW] > best)) ||
                (!find_max_i && (volt_i[i*VW +: VW] < best))) begin
               found_o = 1'b1;
               best    = volt_i[i*VW +: VW];
               idx_o   = IXW'(i);
            end
         end
      end
   end
endmodule

// File: rtl/mmc_maxmin_sel.sv
module mmc_maxmin_sel
   import mmc_sel_pkg::*;
#(
   parameter int N_SM = 8,
   parameter int VW   = 10,
   parameter int IW   = 8,
   localparam int CW  = $clog2(N_SM + 1),
   localparam int IXW = (N_SM > 1) ? $clog2(N_SM) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [CW-1:0]        req_cnt_i,
   input  logic signed [IW-1:0] arm_cur_i,
   input  logic [N_SM*VW-1:0]   volt_i,
   input  logic [VW-1:0]        thresh_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic [N_SM-1:0]      ins_o
);
   generate
      if (N_SM < 2) begin : g_bad_n
         $error("mmc_maxmin_sel: N_SM must be at least 2");
      end
      if (VW < 2) begin : g_bad_vw
         $error("mmc_maxmin_sel: VW must be at least 2");
      end
      if (IW < 2) begin : g_bad_iw
         $error("mmc_maxmin_sel: IW must be at least 2");
      end
   endgenerate

   sel_state_e           state_q;
   logic [N_SM-1:0]      ins_q;
   logic [CW-1:0]        prev_q;
   logic [CW-1:0]        rem_q;
   logic                 up_q;
   logic                 dis_q;
   logic [N_SM*VW-1:0]   volt_q;
   logic [VW-1:0]        thr_q;

   logic [CW-1:0]        req_clamp;
   logic [IXW-1:0]       a_idx, b_idx;
   logic                 a_ok, b_ok;
   logic [VW-1:0]        va, vb, gap;

   assign req_clamp = (req_cnt_i > CW'(N_SM)) ? CW'(N_SM) : req_cnt_i;

   // Scan over inserted modules: max when charging, min when discharging.
   mmc_extreme_finder #(.N_SM(N_SM), .VW(VW)) u_find_ins (
      .volt_i     (volt_q),
      .elig_i     (ins_q),
      .find_max_i (~dis_q),
      .idx_o      (a_idx),
      .found_o    (a_ok)
   );

   // Scan over bypassed modules: min when charging, max when discharging.
   mmc_extreme_finder #(.N_SM(N_SM), .VW(VW)) u_find_byp (
      .volt_i     (volt_q),
      .elig_i     (~ins_q),
      .find_max_i (dis_q),
      .idx_o      (b_idx),
      .found_o    (b_ok)
   );

   assign va  = volt_q[a_idx*VW +: VW];
   assign vb  = volt_q[b_idx*VW +: VW];
   assign gap = (va > vb) ? (va - vb) : (vb - va);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ins_q   <= '0;
         prev_q  <= '0;
         rem_q   <= '0;
         up_q    <= 1'b0;
         dis_q   <= 1'b0;
         volt_q  <= '0;
         thr_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  volt_q <= volt_i;
                  thr_q  <= thresh_i;
                  dis_q  <= arm_cur_i[IW-1];
                  prev_q <= req_clamp;
                  if (req_clamp > prev_q) begin
                     up_q    <= 1'b1;
                     rem_q   <= req_clamp - prev_q;
                     state_q <= ST_STEP;
                  end else if (req_clamp < prev_q) begin
                     up_q    <= 1'b0;
                     rem_q   <= prev_q - req_clamp;
                     state_q <= ST_STEP;
                  end else begin
                     state_q <= ST_SWAP;
                  end
               end
            end
            ST_STEP: begin
               if (up_q && b_ok) ins_q[b_idx] <= 1'b1;
               if (!up_q && a_ok) ins_q[a_idx] <= 1'b0;
               rem_q <= rem_q - 1'b1;
               if (rem_q <= CW'(1)) state_q <= ST_FIN;
            end
            ST_SWAP: begin
               if (a_ok && b_ok && (gap > thr_q)) begin
                  ins_q[a_idx] <= 1'b0;
                  ins_q[b_idx] <= 1'b1;
               end
               state_q <= ST_FIN;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != ST_IDLE);
   assign done_o = (state_q == ST_FIN);
   assign ins_o  = ins_q;
endmodule

// File: rtl/mmc_maxmin_sel_chk.sv
module mmc_maxmin_sel_chk #(
   parameter int N_SM = 8,
   parameter int CW   = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start_i,
   input logic [CW-1:0]   req_cnt_i,
   input logic            busy_o,
   input logic            done_o,
   input logic [N_SM-1:0] ins_o
);
   logic [CW-1:0] exp_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) exp_cnt <= '0;
      else if (start_i && !busy_o)
         exp_cnt <= (req_cnt_i > CW'(N_SM)) ? CW'(N_SM) : req_cnt_i;
   end

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |=> $stable(ins_o));

   // R6
   few_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(ins_o ^ $past(ins_o)) <= 2));

   // R6
   count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($countones(ins_o) == int'(exp_cnt)));

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (!rst_n || ins_o == '0));
endmodule

bind mmc_maxmin_sel mmc_maxmin_sel_chk #(.N_SM(N_SM), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .req_cnt_i (req_cnt_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .ins_o     (ins_o)
);

// File: tb/mmc_maxmin_sel_tb.sv
module mmc_maxmin_sel_tb;
   localparam int N  = 8;
   localparam int VW = 10;
   localparam int IW = 8;
   localparam int CW = $clog2(N + 1);
   localparam time CLK_PERIOD = 10ns;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 start_i = 1'b0;
   logic [CW-1:0]        req_cnt_i = '0;
   logic signed [IW-1:0] arm_cur_i = '0;
   logic [N*VW-1:0]      volt_i = '0;
   logic [VW-1:0]        thresh_i = '0;
   logic                 busy_o, done_o;
   logic [N-1:0]         ins_o;

   int checks = 0;
   int failures = 0;
   int m_ins[N];
   int m_prev = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mmc_maxmin_sel #(.N_SM(N), .VW(VW), .IW(IW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_cnt_i(req_cnt_i),
      .arm_cur_i(arm_cur_i), .volt_i(volt_i), .thresh_i(thresh_i),
      .busy_o(busy_o), .done_o(done_o), .ins_o(ins_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Index of the extreme voltage among modules in state st; -1 if none.
   function automatic int pick(input int v[N], input int st, input bit want_max);
      int idx = -1;
      for (int i = 0; i < N; i++) begin
         if (m_ins[i] == st) begin
            if (idx < 0 || (want_max && v[i] > v[idx]) || (!want_max && v[i] < v[idx]))
               idx = i;
         end
      end
      return idx;
   endfunction

   function automatic int model_vec();
      int r = 0;
      for (int i = 0; i < N; i++) r |= (m_ins[i] << i);
      return r;
   endfunction

   task automatic run_upd(input int req, input int cur, input int thr,
                          input bit tie, input bit poke, input string note);
      int v[N];
      int clamp, dn, lat, seen, ia, ib, gap;
      bit dis;
      string tag;
      for (int i = 0; i < N; i++) begin
         v[i] = tie ? 7 : int'($urandom_range(0, 15));
         volt_i[i*VW +: VW] = VW'(v[i]);
      end
      dis   = (cur < 0);
      clamp = (req > N) ? N : req;
      dn    = clamp - m_prev;
      lat   = (dn == 0) ? 1 : ((dn > 0) ? dn : -dn);
      tag   = (dn > 0) ? (dis ? "R3" : "R2") : ((dn < 0) ? "R4" : "R5");
      if (dn > 0) begin
         for (int k = 0; k < dn; k++) m_ins[pick(v, 0, dis)] = 1;
      end else if (dn < 0) begin
         for (int k = 0; k < -dn; k++) m_ins[pick(v, 1, !dis)] = 0;
      end else begin
         ia = pick(v, 1, !dis);
         ib = pick(v, 0, dis);
         if (ia >= 0 && ib >= 0) begin
            gap = (v[ia] > v[ib]) ? v[ia] - v[ib] : v[ib] - v[ia];
            if (gap > thr) begin
               m_ins[ia] = 0;
               m_ins[ib] = 1;
            end
         end
      end
      m_prev = clamp;

      @(negedge clk);
      start_i   = 1'b1;
      req_cnt_i = CW'(req);
      arm_cur_i = IW'(cur);
      thresh_i  = VW'(thr);
      seen = -1;
      for (int n = 1; n <= lat + 1; n++) begin
         @(negedge clk);
         if (n == 1) start_i = 1'b0;
         if (poke && n == 2) begin
            start_i   = 1'b1;
            req_cnt_i = '0;
         end
         if (poke && n == 3) start_i = 1'b0;
         if (done_o && seen < 0) seen = n;
      end
      start_i = 1'b0;
      chk(seen == lat + 1, {"R10 latency ", note}, seen, lat + 1);
      chk(int'(ins_o) == model_vec(), {tag, " ", note}, int'(ins_o), model_vec());
      chk($countones(ins_o) == clamp, {"R6 count ", note}, $countones(ins_o), clamp);
      @(negedge clk);
      chk(!done_o, {"R10 pulse ", note}, int'(done_o), 0);
      chk(int'(ins_o) == model_vec(), {"R10 idle hold ", note}, int'(ins_o), model_vec());
   endtask

   initial begin
      repeat (500000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) m_ins[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ins_o == '0, "R1 ins", int'(ins_o), 0);
      chk(!done_o, "R1 done", int'(done_o), 0);
      chk(!busy_o, "R1 busy", int'(busy_o), 0);

      run_upd(3,   20, 0,  0, 0, "R2 charge up");
      run_upd(6, -20, 0,  0, 0, "R3 discharge up");
      run_upd(4,   30, 0,  0, 0, "R4 charge down");
      run_upd(2,  -30, 0,  0, 0, "R4 discharge down");
      run_upd(2,   10, 0,  0, 0, "R5 swap thr0");
      run_upd(2,  -10, 15, 0, 0, "R5 no swap thr15");
      run_upd(5,   10, 0,  1, 0, "R7 tie up");
      run_upd(3,  -10, 0,  1, 0, "R7 tie down");
      run_upd(15,  10, 0,  0, 0, "R8 clamp");
      run_upd(2,    0, 0,  0, 0, "R9 zero current down");
      run_upd(4,    0, 0,  0, 0, "R9 zero current up");
      run_upd(8,  -5, 0,  0, 1, "R10 strobe while busy");
      run_upd(8,    5, 3,  0, 0, "R5 full arm");
      run_upd(0,    5, 0,  0, 0, "R4 empty arm");

      for (int t = 0; t < 400; t++) begin
         run_upd(int'($urandom_range(0, 10)),
                 int'($urandom_range(0, 8)) - 4,
                 int'($urandom_range(0, 6)),
                 ($urandom_range(0, 9) == 0), 0, "R6 sweep");
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule